// File: doc/BRIEF.md
# TMDS Clock Lane Pattern Generator

This block produces the 10-bit characters that feed the clock lane of a TMDS serializer. Instead of a fixed clock character, the lane is driven from a set of four programmable 10-bit words. The generator emits them in a fixed rotation, one word per character clock. With every word set to 0x01F, each character holds five zeros and then five ones, so the lane toggles once per character (divide-by-10). With words 0x000, 0x000, 0x3FF, 0x3FF, the lane completes one period every four characters (divide-by-40). That slower waveform suits character rates above 340 MHz.

The host writes the four words through two 32-bit pattern registers and then commits them in two steps through a control register. Writing 1 latches the pattern registers into a shadow set. Writing 2 copies the shadow set into the active set and restarts the rotation at word 0. Pattern register writes and a latch step do not disturb the running waveform. Only the start step changes it, so a reprogramming can be staged while the lane keeps running.

Top module: `tmds_clk_pattern_gen`

## Requirements
- R1: After reset and until the first accepted start, `clk_word` holds 0x01F.
- R2: Register address 0 carries word 0 in bits 9:0 and word 1 in bits 25:16. Address 1 carries word 2 in bits 9:0 and word 3 in bits 25:16. All other data bits are ignored.
- R3: A write of value 1 to the control address (2) copies both pattern registers into the shadow set. It does not change `clk_word`.
- R4: A write of value 2 to the control address is a start when it follows a latch. On the clock edge that samples the start, the active set takes the shadow set and `clk_word` becomes word 0.
- R5: While running, `clk_word` steps through words 0, 1, 2, 3 and repeats, one word per clock.
- R6: Writes to the pattern registers while running leave `clk_word` unchanged.
- R7: A write of value 2 with no latch since reset or since the last start is ignored. The rotation is not restarted.
- R8: Writes to the control address with any value other than 1 or 2 are ignored.
- R9: With words 0x000, 0x000, 0x3FF, 0x3FF the output repeats every four characters. With all words at 0x01F it is constant 0x01F.
- R10: A latch issued while running does not change the rotation. The old words continue until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 and 1 are pattern registers, 2 is control |
| wr_data | input | 32 | Register write data |
| clk_word | output | 10 | Clock-lane character to the serializer |

## Verification
Some properties are checked on every cycle. The output holds the reset word while idle. A latch copies the pattern registers into the shadow set exactly. The shadow set stays fixed on every other cycle, including after ignored control values. A start puts the shadow's word 0 on the output. Once a rotation has run a full round, the output repeats with a period of four.

The bench scenarios cover the rest. They show that a start without a prior latch is dropped and that a latch while running leaves the old rotation in place. They show that the ignored upper data bits never reach the words. They also produce the two concrete lane waveforms, the divide-by-10 and the divide-by-40.

// File: rtl/tmds_ckpat_pkg.sv
package tmds_ckpat_pkg;
    localparam int CKW_W         = 10;
    localparam int NUM_WORDS     = 4;
    localparam int BUS_W         = 32;
    localparam int HALF_W        = 16;
    localparam int ADDR_W        = 2;
    localparam int WORDS_PER_REG = BUS_W / HALF_W;
    localparam int NUM_PREG      = NUM_WORDS / WORDS_PER_REG;
    localparam int IDX_W         = $clog2(NUM_WORDS);
    localparam int CTRL_ADDR     = NUM_PREG;
    localparam int CTRL_LOAD     = 1;
    localparam int CTRL_START    = 2;

    typedef logic [CKW_W-1:0]                  ckword_t;
    typedef logic [NUM_WORDS-1:0][CKW_W-1:0]   ckset_t;
endpackage

// File: rtl/tmds_ckpat_regs.sv
module tmds_ckpat_regs
    import tmds_ckpat_pkg::*;
#(
    parameter ckword_t RESET_WORD = 10'h01F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output ckset_t            shadow_o,
    output logic              start_o
);
    typedef struct packed {
        ckset_t host;
        ckset_t shadow;
        logic   armed;
    } regs_state_t;

    localparam regs_state_t RST_STATE = '{
        host:   {NUM_WORDS{RESET_WORD}},
        shadow: {NUM_WORDS{RESET_WORD}},
        armed:  1'b0
    };

    regs_state_t s_q, s_d;

    logic                 ctrl_hit;
    logic                 load_stb;
    logic [NUM_WORDS-1:0] field_hit;
    ckword_t              field_w [NUM_WORDS];

    // Each word sits in register k/WORDS_PER_REG at lane offset (k%WORDS_PER_REG)*HALF_W.
    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_field
        localparam int REG_IDX = k / WORDS_PER_REG;
        localparam int LANE    = k % WORDS_PER_REG;
        assign field_hit[k] = wr_en && (wr_addr == ADDR_W'(REG_IDX));
        assign field_w[k]   = wr_data[LANE*HALF_W +: CKW_W];
    end

    assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign load_stb = ctrl_hit && (wr_data == BUS_W'(CTRL_LOAD));
    assign start_o  = ctrl_hit && (wr_data == BUS_W'(CTRL_START)) && s_q.armed;

    always_comb begin
        s_d = s_q;
        for (int k = 0; k < NUM_WORDS; k++) begin
            if (field_hit[k]) begin
                s_d.host[k] = field_w[k];
            end
        end
        if (load_stb) begin
            s_d.shadow = s_q.host;
            s_d.armed  = 1'b1;
        end else if (start_o) begin
            s_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign shadow_o = s_q.shadow;

    // R3: a latch step copies the pattern registers into the shadow set
    assert_latch_copy_R3: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (shadow_o == $past(s_q.host)));

    // R6: without a latch step, pattern writes never reach the shadow set
    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load_stb |=> $stable(shadow_o));

    // R8: control values other than latch or start change nothing
    assert_ctrl_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_hit && (wr_data != BUS_W'(CTRL_LOAD)) && (wr_data != BUS_W'(CTRL_START)))
        |=> ($stable(shadow_o) && ($past(s_q.armed) == s_q.armed)));
endmodule

// File: rtl/tmds_ckpat_seq.sv
module tmds_ckpat_seq
    import tmds_ckpat_pkg::*;
#(
    parameter ckword_t RESET_WORD = 10'h01F
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  ckset_t  shadow_i,
    output ckword_t word_o
);
    typedef struct packed {
        ckset_t           active;
        logic [IDX_W-1:0] idx;
        logic             running;
        ckword_t          word;
    } seq_state_t;

    localparam seq_state_t RST_STATE = '{
        active:  {NUM_WORDS{RESET_WORD}},
        idx:     '0,
        running: 1'b0,
        word:    RESET_WORD
    };

    seq_state_t s_q, s_d;

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(NUM_WORDS - 1)) ? '0 : i + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (start_i) begin
            s_d.active  = shadow_i;
            s_d.word    = shadow_i[0];
            s_d.idx     = step_idx('0);
            s_d.running = 1'b1;
        end else if (s_q.running) begin
            s_d.word    = s_q.active[s_q.idx];
            s_d.idx     = step_idx(s_q.idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= RST_STATE;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_o = s_q.word;

    // Checker-only count of cycles since the last start, saturating.
    logic [3:0] chk_run_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            chk_run_q <= '0;
        end else if (start_i) begin
            chk_run_q <= 4'd1;
        end else if (s_q.running && chk_run_q != 4'hF) begin
            chk_run_q <= chk_run_q + 4'd1;
        end
    end

    // R1: before the first start the lane carries the reset word
    assert_idle_word_R1: assert property (@(posedge clk) disable iff (rst)
        !s_q.running |-> (word_o == RESET_WORD));

    // R4: a start puts shadow word 0 on the lane at the next edge
    assert_start_first_R4: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (word_o == $past(shadow_i[0])));

    // R5: after a full round the output repeats with period NUM_WORDS
    assert_period_R5: assert property (@(posedge clk) disable iff (rst)
        (chk_run_q > 4'(NUM_WORDS)) |-> (word_o == $past(word_o, NUM_WORDS)));
endmodule

// File: rtl/tmds_clk_pattern_gen.sv
module tmds_clk_pattern_gen
    import tmds_ckpat_pkg::*;
#(
    parameter ckword_t RESET_WORD = 10'h01F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [CKW_W-1:0]  clk_word
);
    ckset_t shadow;
    logic   start;

    tmds_ckpat_regs #(
        .RESET_WORD (RESET_WORD)
    ) i_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .shadow_o (shadow),
        .start_o  (start)
    );

    tmds_ckpat_seq #(
        .RESET_WORD (RESET_WORD)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .shadow_i (shadow),
        .word_o   (clk_word)
    );
endmodule

// File: tb/test_tmds_clk_pattern_gen.sv
module test_tmds_clk_pattern_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [9:0]  clk_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmds_clk_pattern_gen i_tmds_clk_pattern_gen (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clk_word (clk_word)
    );

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    logic [9:0] exp_q[$];

    // Reference model of the requirements; pushes the expected word after each edge.
    logic [9:0] m_pat [4];
    logic [9:0] m_sh  [4];
    logic [9:0] m_act [4];
    bit         m_arm;
    bit         m_run;
    int         m_idx;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) begin
                m_pat[k] = 10'h01F; m_sh[k] = 10'h01F; m_act[k] = 10'h01F;
            end
            m_arm = 0; m_run = 0; m_idx = 0;
            exp_q.delete();
        end else begin
            logic [9:0] nxt;
            bit         st;
            st = wr_en && wr_addr == 2'd2 && wr_data == 32'd2 && m_arm;
            if (st) begin
                for (int k = 0; k < 4; k++) m_act[k] = m_sh[k];
                nxt = m_act[0]; m_idx = 1; m_run = 1; m_arm = 0;
            end else if (m_run) begin
                nxt = m_act[m_idx]; m_idx = (m_idx + 1) % 4;
            end else begin
                nxt = 10'h01F;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin m_pat[0] = wr_data[9:0]; m_pat[1] = wr_data[25:16]; end
                    2'd1: begin m_pat[2] = wr_data[9:0]; m_pat[3] = wr_data[25:16]; end
                    2'd2: if (wr_data == 32'd1) begin
                              for (int k = 0; k < 4; k++) m_sh[k] = m_pat[k];
                              m_arm = 1;
                          end
                    default: ;
                endcase
            end
            exp_q.push_back(nxt);
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            logic [9:0] e;
            e = exp_q.pop_front();
            checks++;
            if (clk_word !== e) begin
                failures++;
                $display("FAIL %s scoreboard: got %h expected %h", cur_req, clk_word, e);
            end
        end
    end

    task automatic check_now(input logic [9:0] exp, input string req);
        checks++;
        if (clk_word !== exp) begin
            failures++;
            $display("FAIL %s direct: got %h expected %h", req, clk_word, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_now(10'h01F, "R1");
        repeat (5) @(negedge clk);
        check_now(10'h01F, "R1");

        cur_req = "R7";
        wr(2'd2, 32'd2);
        check_now(10'h01F, "R7");

        cur_req = "R2";
        wr(2'd0, 32'hFEABFD23);
        wr(2'd1, 32'h03C500F0);
        cur_req = "R8";
        wr(2'd2, 32'd3);
        wr(2'd2, 32'd0);
        check_now(10'h01F, "R8");

        cur_req = "R3";
        wr(2'd2, 32'd1);
        check_now(10'h01F, "R3");
        repeat (3) @(negedge clk);
        cur_req = "R8";
        wr(2'd2, 32'd7);
        check_now(10'h01F, "R8");

        cur_req = "R4";
        wr(2'd2, 32'd2);
        check_now(10'h123, "R4");
        cur_req = "R5";
        @(negedge clk); check_now(10'h2AB, "R2");
        @(negedge clk); check_now(10'h0F0, "R5");
        @(negedge clk); check_now(10'h3C5, "R5");
        @(negedge clk); check_now(10'h123, "R5");

        cur_req = "R6";
        wr(2'd0, 32'h01550066);
        check_now(10'h2AB, "R6");
        wr(2'd1, 32'h02220399);
        check_now(10'h0F0, "R6");

        cur_req = "R7";
        wr(2'd2, 32'd2);
        check_now(10'h3C5, "R7");

        cur_req = "R10";
        wr(2'd2, 32'd1);
        check_now(10'h123, "R10");
        @(negedge clk); check_now(10'h2AB, "R10");
        cur_req = "R4";
        wr(2'd2, 32'd2);
        check_now(10'h066, "R4");
        @(negedge clk); check_now(10'h155, "R5");
        @(negedge clk); check_now(10'h399, "R5");
        @(negedge clk); check_now(10'h222, "R5");
        @(negedge clk);

        cur_req = "R9";
        wr(2'd0, 32'h00000000);
        wr(2'd1, 32'h03FF03FF);
        wr(2'd2, 32'd1);
        wr(2'd2, 32'd2);
        for (int k = 0; k < 8; k++) begin
            check_now(((k % 4) < 2) ? 10'h000 : 10'h3FF, "R9");
            @(negedge clk);
        end

        wr(2'd0, 32'h001F001F);
        wr(2'd1, 32'h001F001F);
        wr(2'd2, 32'd1);
        wr(2'd2, 32'd2);
        for (int k = 0; k < 8; k++) begin
            check_now(10'h01F, "R9");
            @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule